// File: doc/BRIEF.md
# Reset Release Timeout Sequencer

This block decides when a small processor core may leave reset after power is applied, after a supply dip, after the external master-clear pin is let go, and after a wake-up from sleep. It watches a power-on pulse and a brown-out detect level. Once the supply is good it runs up to two timers in a fixed order. The first is a power-up timer of fixed length. The second is an oscillator start-up counter that waits for a crystal to settle. The two chip-configuration inputs choose which of these timers the sequence needs. The block drives an internal reset and a separate run permission for the core.

The timers are tied to the supply events, not to the master-clear pin. A board can therefore hold master-clear low until both timers have expired, and the core starts on the very next clock once the pin is released. A wake-up from sleep does not reset the core. It only withholds run permission while the oscillator settles, and it does so only in crystal modes.

The sequencer has five states:
- HOLD: supply not yet good.
- PWRT: power-up timer running.
- OST: oscillator start-up count running.
- RUN: all timers done.
- WAKE: oscillator settling after sleep.

Its transitions are:
- HOLD to PWRT, HOLD to OST or HOLD to RUN, chosen by the configuration inputs when the brown-out detect is low.
- PWRT to OST in crystal mode, or PWRT to RUN in RC mode, on power-up timer expiry.
- OST to RUN on count expiry.
- RUN to WAKE on a wake request in crystal mode.
- WAKE to RUN on count expiry.
- Any state to HOLD while the brown-out detect is high.

The power-on pulse resets the sequencer asynchronously to HOLD.

Top module: `rst_tmo_seq`

## Requirements
- R1: While `por_pulse` is 1, `rst_int` is 1 and `core_run` is 0, taking effect at once without waiting for a clock edge.
- R2: With `osc_rc`=0 (crystal) and `pwrt_en_n`=0 (timer on), after `por_pulse` falls, `rst_int` falls and `core_run` rises at rising edge number 1+PWRT_TICKS+OST_CYCLES, counting the first edge after the fall as 1.
- R3: With `osc_rc`=0 and `pwrt_en_n`=1, the release happens at rising edge number 1+OST_CYCLES after `por_pulse` falls.
- R4: With `osc_rc`=1 (RC), the release happens at edge 1+PWRT_TICKS when `pwrt_en_n`=0, and at edge 1 when `pwrt_en_n`=1.
- R5: While `bod_det` is 1, `rst_int` is 1 from the next rising edge. After `bod_det` falls, the release delay equals the power-on delay for the same configuration.
- R6: A brown-out during a running power-up timer or start-up count restarts the sequence. The full delay is then counted from the fall of `bod_det`.
- R7: While `mclr_n` is 0, `rst_int` stays 1 and `core_run` stays 0, but the timers keep running. If the pin is released after they expire, release happens at the first rising edge after `mclr_n` rises.
- R8: When `mclr_n` falls during normal running, `rst_int` is 1 from the next rising edge. Its later release starts no timer.
- R9: A one-cycle `wake_req`=1 while running in crystal mode drops `core_run` at that edge and keeps `rst_int` at 0. `core_run` rises again OST_CYCLES edges later.
- R10: In RC mode a `wake_req` has no effect on `core_run`.
- R11: `rst_int` and `core_run` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all timing counts its rising edges |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous reset of the block |
| bod_det | input | 1 | Brown-out detect level, active high |
| mclr_n | input | 1 | External master-clear, active low |
| wake_req | input | 1 | Wake-from-sleep request, one-cycle pulse |
| osc_rc | input | 1 | 1 = RC oscillator (no start-up count), 0 = crystal-type oscillator |
| pwrt_en_n | input | 1 | Power-up timer enable, active low |
| rst_int | output | 1 | Internal reset to the core, active high |
| core_run | output | 1 | Core may execute |

## Verification
The assertions assume that `osc_rc` and `pwrt_en_n` are fixed configuration inputs that stay still while a sequence is running. They also assume that `wake_req` is a single-cycle pulse. The bench changes configuration only while `por_pulse` or `bod_det` holds the block in HOLD. It drives every input at the falling clock edge, and it raises a wake request only while the core is already running.

// File: rtl/rst_tmo_pkg.sv
package rst_tmo_pkg;
    typedef enum logic [2:0] {
        ST_HOLD = 3'd0,
        ST_PWRT = 3'd1,
        ST_OST  = 3'd2,
        ST_RUN  = 3'd3,
        ST_WAKE = 3'd4
    } seq_state_e;
endpackage

// File: rtl/rst_tmo_timer.sv
module rst_tmo_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // done marks the last cycle of a window of 'limit' counting cycles
    assign done = (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en && !done)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rst_tmo_fsm.sv
module rst_tmo_fsm
    import rst_tmo_pkg::*;
(
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       bod_det,
    input  logic       mclr_n,
    input  logic       wake_req,
    input  logic       osc_rc,
    input  logic       pwrt_en_n,
    input  logic       tmr_done,
    output seq_state_e state_q,
    output logic       tmr_clr,
    output logic       tmr_en,
    output logic       rst_int,
    output logic       core_run
);
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!bod_det) begin
                    if (!pwrt_en_n)   state_d = ST_PWRT;
                    else if (!osc_rc) state_d = ST_OST;
                    else              state_d = ST_RUN;
                end
            end
            ST_PWRT: begin
                if (bod_det)       state_d = ST_HOLD;
                else if (tmr_done) state_d = osc_rc ? ST_RUN : ST_OST;
            end
            ST_OST: begin
                if (bod_det)       state_d = ST_HOLD;
                else if (tmr_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (bod_det)                 state_d = ST_HOLD;
                else if (wake_req && !osc_rc) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (bod_det)       state_d = ST_HOLD;
                else if (tmr_done) state_d = ST_RUN;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    assign tmr_clr = (state_d != state_q);
    assign tmr_en  = (state_q == ST_PWRT) || (state_q == ST_OST) || (state_q == ST_WAKE);

    // state register
    always_ff @(posedge clk or posedge por_pulse) begin
        if (por_pulse) state_q <= ST_HOLD;
        else           state_q <= state_d;
    end

    // registered outputs, taken from the next state so release lines up with entry to RUN
    always_ff @(posedge clk or posedge por_pulse) begin
        if (por_pulse) begin
            rst_int  <= 1'b1;
            core_run <= 1'b0;
        end else begin
            rst_int  <= !((state_d == ST_RUN) || (state_d == ST_WAKE)) || !mclr_n;
            core_run <= (state_d == ST_RUN) && mclr_n;
        end
    end
endmodule

// File: rtl/rst_tmo_seq.sv
module rst_tmo_seq #(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic por_pulse,
    input  logic bod_det,
    input  logic mclr_n,
    input  logic wake_req,
    input  logic osc_rc,
    input  logic pwrt_en_n,
    output logic rst_int,
    output logic core_run
);
    import rst_tmo_pkg::*;

    localparam int MAX_LEN = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_e       state_q;
    logic             tmr_clr, tmr_en, tmr_done;
    logic [CNT_W-1:0] tmr_limit;

    assign tmr_limit = (state_q == ST_PWRT) ? CNT_W'(PWRT_TICKS) : CNT_W'(OST_CYCLES);

    rst_tmo_fsm i_fsm (
        .clk       (clk),
        .por_pulse (por_pulse),
        .bod_det   (bod_det),
        .mclr_n    (mclr_n),
        .wake_req  (wake_req),
        .osc_rc    (osc_rc),
        .pwrt_en_n (pwrt_en_n),
        .tmr_done  (tmr_done),
        .state_q   (state_q),
        .tmr_clr   (tmr_clr),
        .tmr_en    (tmr_en),
        .rst_int   (rst_int),
        .core_run  (core_run)
    );

    rst_tmo_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .arst  (por_pulse),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .limit (tmr_limit),
        .done  (tmr_done)
    );
endmodule

// File: rtl/rst_tmo_chk.sv
module rst_tmo_chk (
    input logic clk,
    input logic por_pulse,
    input logic bod_det,
    input logic mclr_n,
    input logic wake_req,
    input logic osc_rc,
    input logic rst_int,
    input logic core_run
);
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (por_pulse)
        !(rst_int && core_run)); // R11

    AST_MCLR_HOLD: assert property (@(posedge clk) disable iff (por_pulse)
        !mclr_n |=> (rst_int && !core_run)); // R8

    AST_BOD_HOLD: assert property (@(posedge clk) disable iff (por_pulse)
        bod_det |=> rst_int); // R5

    AST_RELEASE_PIN: assert property (@(posedge clk) disable iff (por_pulse)
        $rose(core_run) |-> $past(mclr_n)); // R7

    AST_WAKE_XTAL: assert property (@(posedge clk) disable iff (por_pulse)
        (wake_req && !osc_rc && core_run && mclr_n && !bod_det) |=> (!core_run && !rst_int)); // R9

    AST_WAKE_RC: assert property (@(posedge clk) disable iff (por_pulse)
        (wake_req && osc_rc && core_run && mclr_n && !bod_det) |=> core_run); // R10
endmodule

bind rst_tmo_seq rst_tmo_chk i_chk (
    .clk       (clk),
    .por_pulse (por_pulse),
    .bod_det   (bod_det),
    .mclr_n    (mclr_n),
    .wake_req  (wake_req),
    .osc_rc    (osc_rc),
    .rst_int   (rst_int),
    .core_run  (core_run)
);

// File: tb/test_rst_tmo_seq.sv
module test_rst_tmo_seq;
    localparam int P = 72;
    localparam int O = 1024;

    logic clk = 1'b0;
    logic por_pulse, bod_det, mclr_n, wake_req, osc_rc, pwrt_en_n;
    logic rst_int, core_run;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        string tag;
        int    lat;
    } exp_t;
    exp_t exp_q[$];
    event started;

    always #4 clk = ~clk;

    rst_tmo_seq #(.PWRT_TICKS(P), .OST_CYCLES(O)) i_rst_tmo_seq (
        .clk(clk), .por_pulse(por_pulse), .bod_det(bod_det), .mclr_n(mclr_n),
        .wake_req(wake_req), .osc_rc(osc_rc), .pwrt_en_n(pwrt_en_n),
        .rst_int(rst_int), .core_run(core_run)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // driver: push expected release edge, then mark the start point
    task automatic kick(input string tag, input int lat);
        exp_t e;
        e.tag = tag;
        e.lat = lat;
        exp_q.push_back(e);
        ->started;
    endtask

    task automatic wait_empty();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // monitor: count rising edges until core_run rises, then compare
    initial begin
        forever begin
            int n;
            exp_t e;
            @(started);
            n = 0;
            while (1) begin
                @(posedge clk);
                #1;
                n++;
                if (core_run || n > 5000) break;
            end
            e = exp_q.pop_front();
            chk(n == e.lat, e.tag, n, e.lat);
            chk(rst_int == 1'b0, {e.tag, " rst_int low at release"}, int'(rst_int), 0);
        end
    end

    // watchdog
    initial begin
        #(200000 * 8);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic power_on(input string tag, input bit rc, input bit en_n, input int lat);
        por_pulse = 1'b1;
        #1;
        chk(rst_int && !core_run, "R1 async reset", {rst_int, core_run}, 2'b10);
        osc_rc    = rc;
        pwrt_en_n = en_n;
        cycles(3);
        chk(rst_int && !core_run, "R1 held reset", {rst_int, core_run}, 2'b10);
        por_pulse = 1'b0;
        kick(tag, lat);
        wait_empty();
    endtask

    initial begin
        por_pulse = 1'b1; bod_det = 1'b0; mclr_n = 1'b1; wake_req = 1'b0;
        osc_rc = 1'b0; pwrt_en_n = 1'b0;
        cycles(3);
        chk(rst_int && !core_run, "R1 reset state", {rst_int, core_run}, 2'b10);

        // R2/R3/R4: power-on delays per configuration
        power_on("R2 xtal timer on", 1'b0, 1'b0, 1 + P + O);
        power_on("R3 xtal timer off", 1'b0, 1'b1, 1 + O);
        power_on("R4 rc timer on", 1'b1, 1'b0, 1 + P);
        power_on("R4 rc timer off", 1'b1, 1'b1, 1);

        // R5: brown-out while running, crystal, timer on
        power_on("R2 xtal again", 1'b0, 1'b0, 1 + P + O);
        bod_det = 1'b1;
        @(posedge clk); #1;
        chk(rst_int && !core_run, "R5 brown-out asserts reset", {rst_int, core_run}, 2'b10);
        cycles(5);
        bod_det = 1'b0;
        kick("R5 brown-out xtal", 1 + P + O);
        wait_empty();
        bod_det = 1'b1;
        osc_rc  = 1'b1;
        cycles(3);
        bod_det = 1'b0;
        kick("R5 brown-out rc", 1 + P);
        wait_empty();

        // R6: restart during power-up timer, then during start-up count
        osc_rc  = 1'b0;
        bod_det = 1'b1;
        cycles(2);
        bod_det = 1'b0;
        cycles(30);
        bod_det = 1'b1;
        cycles(2);
        bod_det = 1'b0;
        kick("R6 restart in power-up timer", 1 + P + O);
        wait_empty();
        bod_det = 1'b1;
        cycles(2);
        bod_det = 1'b0;
        cycles(P + 100);
        chk(rst_int == 1'b1, "R6 still in start-up count", int'(rst_int), 1);
        bod_det = 1'b1;
        cycles(2);
        bod_det = 1'b0;
        kick("R6 restart in start-up count", 1 + P + O);
        wait_empty();

        // R7: master-clear held low across the whole power-on sequence
        por_pulse = 1'b1;
        mclr_n    = 1'b0;
        cycles(3);
        por_pulse = 1'b0;
        cycles(P + O + 20);
        chk(rst_int && !core_run, "R7 pin holds reset", {rst_int, core_run}, 2'b10);
        mclr_n = 1'b1;
        kick("R7 late pin release", 1);
        wait_empty();

        // R8: master-clear during running
        mclr_n = 1'b0;
        @(posedge clk); #1;
        chk(rst_int && !core_run, "R8 pin asserts reset", {rst_int, core_run}, 2'b10);
        cycles(10);
        mclr_n = 1'b1;
        kick("R8 pin release no timers", 1);
        wait_empty();

        // R9: wake-up in crystal mode
        wake_req = 1'b1;
        kick("R9 wake xtal", 1 + O);
        @(negedge clk);
        wake_req = 1'b0;
        cycles(5);
        chk(!core_run && !rst_int, "R9 waking, no reset", {rst_int, core_run}, 2'b00);
        wait_empty();

        // R10: wake-up in RC mode is ignored
        por_pulse = 1'b1;
        osc_rc    = 1'b1;
        pwrt_en_n = 1'b1;
        cycles(2);
        por_pulse = 1'b0;
        cycles(3);
        chk(core_run == 1'b1, "R10 running before wake", int'(core_run), 1);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(core_run && !rst_int, "R10 rc wake ignored", {rst_int, core_run}, 2'b01);
            @(negedge clk);
        end
        chk(!(rst_int && core_run), "R11 outputs exclusive", {rst_int, core_run}, 2'b01);

        finish_run();
    end
endmodule